// File: doc/BRIEF.md
# Timed Reset Sequencing Controller

This block turns single writes to a command register into timed reset sequences for a system-management function. Each command bit selects a reset action. The actions are full reboot, normal reboot and memory-only reset. Each action drives a different set of three active-low reset lines: a primary SoC reset, a secondary reset and a memory reset. For a normal reboot, the memory line is included only when the legacy-emulation mode input is high. The selected lines stay low for a fixed hold time and are then released in the same cycle. A second, longer delay follows the release, and then a one-cycle re-initialisation pulse tells the rest of the controller to reload its registers.

The same command register also has two non-reset bits. One latches a power-off request and the other gives a one-cycle sleep notification. A separate write-only halt bit pulls the primary reset low and never lets it go. Only the block reset `rst_n` clears it. A watchdog strobe sets a sticky flag in a small status word. All times are whole milliseconds, converted to cycles through `CYC_PER_MS`. Command writes are single-cycle strobes with no back-pressure. A write that arrives while a sequence runs is dropped. The `busy` output tells the writer when this will happen.

Top module: `reset_sequencer`

## Requirements
- R1: After `rst_n` is released, all three reset lines are high, and `busy`, `pwr_off_req`, `sleep_pulse`, `legacy_rst`, `reinit_pulse` and `status_o` are all zero.
- R2: An accepted write with `cmd_bits[1]` (full reboot) set drives `soc_rst_n`, `sec_rst_n` and `mem_rst_n` low from the cycle after the write.
- R3: An accepted write with `cmd_bits[2]` (normal reboot) set drives `sec_rst_n` low. It drives `mem_rst_n` low only if `legacy_mode` is 1 in the write cycle. It also raises `legacy_rst` for exactly the first cycle of the hold.
- R4: An accepted write with only `cmd_bits[3]` (memory reset) among the reset bits drives `mem_rst_n` low and leaves the other two lines high.
- R5: The asserted lines stay low for exactly `HOLD_MS*CYC_PER_MS` cycles. They are then released in the same cycle.
- R6: `reinit_pulse` is high for one cycle, `REINIT_MS*CYC_PER_MS` cycles after the release. `busy` is already low in that cycle, so a write in that cycle is accepted.
- R7: While `busy` is 1, command writes have no effect: no line, pulse or power-off output changes because of them.
- R8: A write with `halt_we` and `halt_bit` both 1 drives `soc_rst_n` low from the next cycle until `rst_n`. This holds even when a running sequence releases its lines.
- R9: An accepted write with `cmd_bits[0]` set raises `pwr_off_req`, which then stays high until `rst_n`.
- R10: An accepted write with `cmd_bits[4]` set gives a one-cycle `sleep_pulse` in the next cycle. It starts no reset, and `busy` stays low.
- R11: A `wdt_event` strobe sets `status_o[1]`, which stays set until `rst_n`. All other `status_o` bits read 0.
- R12: If several reset bits are written together, the asserted set is the union of the sets each bit selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_bits | input | 5 | Command bits: 0 power off, 1 full reboot, 2 normal reboot, 3 memory reset, 4 sleep notify |
| legacy_mode | input | 1 | Legacy-emulation mode flag |
| halt_we | input | 1 | Halt register write strobe |
| halt_bit | input | 1 | Halt data bit; 1 pulls the primary reset low for good |
| wdt_event | input | 1 | Watchdog reset strobe |
| soc_rst_n | output | 1 | Primary SoC reset, active low |
| sec_rst_n | output | 1 | Secondary reset, active low |
| mem_rst_n | output | 1 | Memory reset, active low |
| legacy_rst | output | 1 | One-cycle reset of the legacy-mode register block |
| reinit_pulse | output | 1 | One-cycle re-initialisation pulse |
| pwr_off_req | output | 1 | Latched power-off request |
| sleep_pulse | output | 1 | One-cycle sleep notification |
| busy | output | 1 | A sequence is running, so command writes are dropped |
| status_o | output | 8 | Status word; bit 1 is the sticky watchdog flag |

## Verification
Two pairs of events can land in the same cycle. In the first, the re-initialisation pulse of one sequence meets the write that starts the next. The bench waits for `reinit_pulse` and drives a normal-reboot write in that same cycle. The scoreboard must then see the new sequence start with the right line pattern and hold time. In the second, a sequence release meets a halt that arrived during the hold. The halt is written mid-hold, and at the release the bench expects the secondary and memory lines to rise while `soc_rst_n` stays low.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int CMD_W     = 5;
  localparam int CB_PWROFF = 0;
  localparam int CB_FULL   = 1;
  localparam int CB_NORMAL = 2;
  localparam int CB_MEM    = 3;
  localparam int CB_SLEEP  = 4;
  localparam int STAT_W    = 8;
  localparam int STAT_WDT  = 1;
  localparam int NUM_LINES = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HOLD = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

  // bit 2 = primary, bit 1 = secondary, bit 0 = memory; 1 = assert
  typedef struct packed {
    logic soc;
    logic sec;
    logic mem;
  } line_mask_t;
endpackage

// File: rtl/rsc_decode.sv
module rsc_decode
  import rsc_pkg::*;
(
  input  logic [CMD_W-1:0] bits,
  input  logic             legacy_mode,
  output line_mask_t       mask,
  output logic             any_reset
);
  always_comb begin
    mask.soc  = bits[CB_FULL];
    mask.sec  = bits[CB_FULL] | bits[CB_NORMAL];
    mask.mem  = bits[CB_FULL] | bits[CB_MEM] | (bits[CB_NORMAL] & legacy_mode);
    any_reset = bits[CB_FULL] | bits[CB_NORMAL] | bits[CB_MEM];
  end
endmodule

// File: rtl/rsc_timer.sv
module rsc_timer
  import rsc_pkg::*;
#(
  parameter int HOLD_CYC   = 5000,
  parameter int REINIT_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic holding,
  output logic busy,
  output logic reinit_pulse
);
  localparam int MAX_CYC = (HOLD_CYC > REINIT_CYC) ? HOLD_CYC : REINIT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] REINIT_LAST = CNT_W'(REINIT_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= '0;
          end
        end
        SEQ_HOLD: begin
          if (cnt_q == HOLD_LAST) begin
            state_q <= SEQ_WAIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_WAIT: begin
          if (cnt_q == REINIT_LAST) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            pulse_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= SEQ_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign holding      = (state_q == SEQ_HOLD);
  assign busy         = (state_q != SEQ_IDLE);
  assign reinit_pulse = pulse_q;
endmodule

// File: rtl/rsc_lines.sv
module rsc_lines
  import rsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              start,
  input  line_mask_t        mask,
  input  logic              holding,
  input  logic              normal_req,
  input  logic              pwr_req,
  input  logic              sleep_req,
  input  logic              halt_set,
  input  logic              wdt_event,
  output logic              soc_rst_n,
  output logic              sec_rst_n,
  output logic              mem_rst_n,
  output logic              legacy_rst,
  output logic              pwr_off_req,
  output logic              sleep_pulse,
  output logic [STAT_W-1:0] status_o
);
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] low;
  logic                 halt_q, pwr_q, sleep_q, legacy_q, wdt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      halt_q   <= 1'b0;
      pwr_q    <= 1'b0;
      sleep_q  <= 1'b0;
      legacy_q <= 1'b0;
      wdt_q    <= 1'b0;
    end else begin
      if (start) mask_q <= mask;
      if (halt_set) halt_q <= 1'b1;
      if (accept && pwr_req) pwr_q <= 1'b1;
      if (wdt_event) wdt_q <= 1'b1;
      sleep_q  <= accept & sleep_req;
      legacy_q <= start & normal_req;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign low[i] = holding & mask_q[i];
  end

  assign soc_rst_n   = ~(low[2] | halt_q);
  assign sec_rst_n   = ~low[1];
  assign mem_rst_n   = ~low[0];
  assign legacy_rst  = legacy_q;
  assign pwr_off_req = pwr_q;
  assign sleep_pulse = sleep_q;

  always_comb begin
    status_o           = '0;
    status_o[STAT_WDT] = wdt_q;
  end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rsc_pkg::*;
#(
  parameter int CYC_PER_MS = 1000,
  parameter int HOLD_MS    = 5,
  parameter int REINIT_MS  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_bits,
  input  logic              legacy_mode,
  input  logic              halt_we,
  input  logic              halt_bit,
  input  logic              wdt_event,
  output logic              soc_rst_n,
  output logic              sec_rst_n,
  output logic              mem_rst_n,
  output logic              legacy_rst,
  output logic              reinit_pulse,
  output logic              pwr_off_req,
  output logic              sleep_pulse,
  output logic              busy,
  output logic [STAT_W-1:0] status_o
);
  localparam int HOLD_CYC   = CYC_PER_MS * HOLD_MS;
  localparam int REINIT_CYC = CYC_PER_MS * REINIT_MS;

  line_mask_t mask;
  logic       any_reset, accept, start, holding, busy_i;

  assign accept = cmd_we & ~busy_i;
  assign start  = accept & any_reset;
  assign busy   = busy_i;

  rsc_decode u_decode (
    .bits        (cmd_bits),
    .legacy_mode (legacy_mode),
    .mask        (mask),
    .any_reset   (any_reset)
  );

  rsc_timer #(
    .HOLD_CYC   (HOLD_CYC),
    .REINIT_CYC (REINIT_CYC)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .holding      (holding),
    .busy         (busy_i),
    .reinit_pulse (reinit_pulse)
  );

  rsc_lines u_lines (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .start       (start),
    .mask        (mask),
    .holding     (holding),
    .normal_req  (cmd_bits[CB_NORMAL]),
    .pwr_req     (cmd_bits[CB_PWROFF]),
    .sleep_req   (cmd_bits[CB_SLEEP]),
    .halt_set    (halt_we & halt_bit),
    .wdt_event   (wdt_event),
    .soc_rst_n   (soc_rst_n),
    .sec_rst_n   (sec_rst_n),
    .mem_rst_n   (mem_rst_n),
    .legacy_rst  (legacy_rst),
    .pwr_off_req (pwr_off_req),
    .sleep_pulse (sleep_pulse),
    .status_o    (status_o)
  );
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int HOLD_CYC = 5000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [4:0] cmd_bits,
  input logic       legacy_mode,
  input logic       halt_we,
  input logic       halt_bit,
  input logic       wdt_event,
  input logic       soc_rst_n,
  input logic       sec_rst_n,
  input logic       mem_rst_n,
  input logic       legacy_rst,
  input logic       reinit_pulse,
  input logic       pwr_off_req,
  input logic       sleep_pulse,
  input logic       busy,
  input logic [7:0] status_o
);
  logic [31:0] low_cnt;
  logic        any_low;
  assign any_low = !(sec_rst_n && mem_rst_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (any_low) low_cnt <= low_cnt + 1;
    else low_cnt <= '0;
  end

  assert_full_all_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && cmd_bits[1]) |=> (!soc_rst_n && !sec_rst_n && !mem_rst_n));

  assert_normal_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && cmd_bits[2] && !cmd_bits[1] && !cmd_bits[3])
      |=> (!sec_rst_n && legacy_rst && (mem_rst_n == !$past(legacy_mode))));

  assert_legacy_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_rst |=> !legacy_rst);

  assert_hold_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_rst_n && mem_rst_n) |-> (low_cnt == HOLD_CYC));

  assert_release_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_rst_n) |-> mem_rst_n);

  assert_reinit_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_pulse |=> !reinit_pulse);

  assert_reinit_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_pulse |-> (!busy && sec_rst_n && mem_rst_n));

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we && cmd_bits[4]) |=> !sleep_pulse);

  assert_halt_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_we && halt_bit) |=> !soc_rst_n);

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!soc_rst_n) && !busy) |-> !soc_rst_n);

  assert_pwr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |=> pwr_off_req);

  assert_sleep_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_pulse |=> !sleep_pulse);

  assert_wdt_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_event || status_o[1]) |=> status_o[1]);

  assert_status_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & 8'hFD) == 8'h00);
endmodule

bind reset_sequencer rsc_checker #(.HOLD_CYC(HOLD_CYC)) u_rsc_checker (.*);

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 4;
  localparam int HOLD       = CPM * 5;
  localparam int REINIT     = CPM * 100;
  localparam int SEQ        = HOLD + REINIT;
  localparam int WD_LIMIT   = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [4:0] cmd_bits = '0;
  logic       legacy_mode = 1'b0;
  logic       halt_we = 1'b0;
  logic       halt_bit = 1'b0;
  logic       wdt_event = 1'b0;
  logic       soc_rst_n, sec_rst_n, mem_rst_n, legacy_rst, reinit_pulse;
  logic       pwr_off_req, sleep_pulse, busy;
  logic [7:0] status_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  reset_sequencer #(.CYC_PER_MS(CPM), .HOLD_MS(5), .REINIT_MS(100)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_bits(cmd_bits),
    .legacy_mode(legacy_mode), .halt_we(halt_we), .halt_bit(halt_bit),
    .wdt_event(wdt_event), .soc_rst_n(soc_rst_n), .sec_rst_n(sec_rst_n),
    .mem_rst_n(mem_rst_n), .legacy_rst(legacy_rst), .reinit_pulse(reinit_pulse),
    .pwr_off_req(pwr_off_req), .sleep_pulse(sleep_pulse), .busy(busy),
    .status_o(status_o)
  );

  typedef struct {
    logic [2:0] lines;  // {soc, sec, mem}, 0 = asserted
    logic       legp;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   halted = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: call right after a negedge; returns one negedge later.
  task automatic write_cmd(input logic [4:0] b, input logic leg, input bit expect_start);
    exp_t e;
    legacy_mode = leg;
    cmd_we      = 1'b1;
    cmd_bits    = b;
    if (expect_start) begin
      e.lines[2] = ~b[1];
      e.lines[1] = ~(b[1] | b[2]);
      e.lines[0] = ~(b[1] | b[3] | (b[2] & leg));
      e.legp     = b[2];
      exp_q.push_back(e);
    end
    @(negedge clk);
    cmd_we   = 1'b0;
    cmd_bits = '0;
  endtask

  // Monitor / scoreboard
  bit   in_seq = 0, waiting = 0;
  int   lowcnt = 0, rcnt = 0;
  exp_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_seq && !(sec_rst_n && mem_rst_n)) begin
        in_seq = 1;
        lowcnt = 1;
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected sequence start", 1, 0);
          cur.lines = {soc_rst_n, sec_rst_n, mem_rst_n};
          cur.legp  = legacy_rst;
        end else begin
          cur = exp_q.pop_front();
          chk({soc_rst_n, sec_rst_n, mem_rst_n} == (cur.lines & {~halted, 2'b11}),
              "R2/R3/R4/R12 line pattern", {soc_rst_n, sec_rst_n, mem_rst_n},
              cur.lines & {~halted, 2'b11});
          chk(legacy_rst == cur.legp, "R3 legacy reset pulse", legacy_rst, cur.legp);
        end
      end else if (in_seq && !(sec_rst_n && mem_rst_n)) begin
        lowcnt++;
        if (lowcnt == 2) chk(legacy_rst == 1'b0, "R3 legacy pulse one cycle", legacy_rst, 0);
      end else if (in_seq) begin
        in_seq = 0;
        chk(lowcnt == HOLD, "R5 hold length", lowcnt, HOLD);
        chk(soc_rst_n == !halted, "R5/R8 primary at release", soc_rst_n, !halted);
        waiting = 1;
        rcnt    = 0;
      end else if (waiting) begin
        rcnt++;
        if (reinit_pulse) begin
          chk(rcnt == REINIT, "R6 reinit delay", rcnt, REINIT);
          waiting = 0;
        end
      end else if (reinit_pulse) begin
        chk(0, "R6 stray reinit pulse", 1, 0);
      end
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk({soc_rst_n, sec_rst_n, mem_rst_n} == 3'b111, "R1 lines after reset",
        {soc_rst_n, sec_rst_n, mem_rst_n}, 7);
    chk(!busy && !pwr_off_req && !sleep_pulse && !legacy_rst && !reinit_pulse,
        "R1 outputs after reset", {busy, pwr_off_req, sleep_pulse, legacy_rst, reinit_pulse}, 0);
    chk(status_o == 8'h00, "R1 status after reset", status_o, 0);

    // R2 full reboot
    write_cmd(5'b00010, 1'b0, 1);
    repeat (SEQ + 4) @(negedge clk);
    // R3 normal reboot, legacy off then on
    write_cmd(5'b00100, 1'b0, 1);
    repeat (SEQ + 4) @(negedge clk);
    write_cmd(5'b00100, 1'b1, 1);
    repeat (SEQ + 4) @(negedge clk);
    // R4 memory only
    write_cmd(5'b01000, 1'b1, 1);
    repeat (SEQ + 4) @(negedge clk);
    // R12 union of normal and memory bits
    write_cmd(5'b01100, 1'b0, 1);
    repeat (SEQ + 4) @(negedge clk);

    // R7 writes while busy dropped
    write_cmd(5'b01000, 1'b0, 1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b1, "R7 busy during hold", busy, 1);
    write_cmd(5'b10011, 1'b0, 0);
    chk(sleep_pulse == 1'b0, "R7 sleep dropped", sleep_pulse, 0);
    chk(pwr_off_req == 1'b0, "R7 power off dropped", pwr_off_req, 0);
    chk(soc_rst_n == 1'b1, "R7 full reboot dropped", soc_rst_n, 1);

    // R6 same-cycle write during reinit pulse
    for (int i = 0; i < SEQ + 10 && !reinit_pulse; i++) @(negedge clk);
    chk(reinit_pulse == 1'b1 && busy == 1'b0, "R6 idle in pulse cycle",
        {reinit_pulse, busy}, 2);
    write_cmd(5'b00100, 1'b1, 1);
    chk(busy == 1'b1, "R6 write in pulse cycle accepted", busy, 1);
    repeat (SEQ + 4) @(negedge clk);

    // R10 sleep
    write_cmd(5'b10000, 1'b0, 0);
    chk(sleep_pulse == 1'b1, "R10 sleep pulse", sleep_pulse, 1);
    chk(busy == 1'b0 && {soc_rst_n, sec_rst_n, mem_rst_n} == 3'b111, "R10 no reset",
        {busy, soc_rst_n, sec_rst_n, mem_rst_n}, 7);
    @(negedge clk);
    chk(sleep_pulse == 1'b0, "R10 pulse one cycle", sleep_pulse, 0);

    // R9 power off
    write_cmd(5'b00001, 1'b0, 0);
    chk(pwr_off_req == 1'b1, "R9 power off set", pwr_off_req, 1);
    chk(busy == 1'b0, "R9 no sequence", busy, 0);
    repeat (10) @(negedge clk);
    chk(pwr_off_req == 1'b1, "R9 power off held", pwr_off_req, 1);

    // R11 watchdog flag
    chk(status_o[1] == 1'b0, "R11 flag clear before strobe", status_o[1], 0);
    wdt_event = 1'b1;
    @(negedge clk);
    wdt_event = 1'b0;
    chk(status_o == 8'h02, "R11 flag set", status_o, 2);
    repeat (5) @(negedge clk);
    chk(status_o == 8'h02, "R11 flag sticky", status_o, 2);

    // R8 halt during a full reboot hold
    write_cmd(5'b00010, 1'b0, 1);
    repeat (5) @(negedge clk);
    halt_we  = 1'b1;
    halt_bit = 1'b1;
    halted   = 1;
    @(negedge clk);
    halt_we  = 1'b0;
    halt_bit = 1'b0;
    chk(soc_rst_n == 1'b0, "R8 primary low after halt", soc_rst_n, 0);
    repeat (SEQ + 4) @(negedge clk);
    chk(soc_rst_n == 1'b0, "R8 primary stays low", soc_rst_n, 0);
    chk(sec_rst_n && mem_rst_n, "R8 others released", {sec_rst_n, mem_rst_n}, 3);

    chk(exp_q.size() == 0 && !in_seq && !waiting, "R5 scoreboard drained",
        exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule